// File: doc/BRIEF.md
# Card Detect and Data Timeout Timers

This block supplies the two programmable waits that a memory-card host controller needs. The first is a debounce wait on the card-present input. A rising presence level is synchronized and then held for a programmed number of host clocks. After that wait the block reports the card as detected and pulses an insert event. If the card goes away, the detected status drops and a remove event pulses.

The second is a data timeout. A wait-for-data strobe arms a down-counter. The counter advances only on cycles where the card-clock enable is high. If no data arrives before the counter runs out, a one-cycle timeout error goes to the interrupt status logic.

Both waits take their lengths from 4-bit fields of a 16-bit option word. Each length is a base count shifted left by the field value. The field value 15 selects a short fixed count that is meant for testing. The same word also carries the bus-width selection, which the block passes out as a flag. The block does not generate the card clock itself; it only receives that clock as an enable.

Top module: `sdc_card_timers`

## Requirements
- R1: The option field in bits 3:0 (value d, 0 to 14) sets the detect wait to DET_BASE<<d host clocks. The detected output and a one-cycle insert pulse rise together DET_BASE<<d + 3 clock edges after card_present_i rises. This figure includes the two synchronizer stages and the edge detect.
- R2: A field value of 15 in either timer field selects TEST_CNT clocks in place of the shifted base count.
- R3: The option field in bits 7:4 (value f, 0 to 14) sets the data timeout to DATA_BASE<<f edges on which card_clk_en_i is high. The count starts after the edge that samples the wait strobe.
- R4: A card that is already present when reset is released is treated as an insertion, with the same timing as R1.
- R5: When the synchronized presence level falls, the detected output clears and a one-cycle remove pulse is given 3 edges after card_present_i falls. Any detect wait still in progress is dropped and gives no insert event.
- R6: Each wait strobe reloads the data timer, so the timeout is counted from the most recent strobe.
- R7: A data-start pulse without a strobe in the same cycle stops the data timer, and no timeout is raised.
- R8: The insert, remove and timeout outputs are pulses one cycle wide, and each occurrence produces exactly one pulse.
- R9: bus_1bit_o equals option bit 15. A value of 1 means a 1-bit bus and 0 means a 4-bit bus.
- R10: While reset is asserted, card_detected_o, insert_evt_o, remove_evt_o and data_timeout_o are all 0.
- R11: card_detected_o stays at 1 and no further events occur while the card remains present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| option_i | input | 16 | Option word: detect field in bits 3:0, data field in bits 7:4, bus width in bit 15 |
| card_present_i | input | 1 | Raw card-present level, asynchronous |
| data_wait_i | input | 1 | Strobe that arms or reloads the data timer |
| data_start_i | input | 1 | Pulse marking the start of data arrival |
| card_clk_en_i | input | 1 | High on host cycles that carry a card-clock tick |
| card_detected_o | output | 1 | Debounced card-present status |
| insert_evt_o | output | 1 | One-cycle pulse when detection completes |
| remove_evt_o | output | 1 | One-cycle pulse when the card is removed |
| data_timeout_o | output | 1 | One-cycle pulse when the data timeout expires |
| bus_1bit_o | output | 1 | 1-bit bus selected |

## Verification
Faults inside the block show up at the ports as events at the wrong time. A counter loaded off by one, or a limit decoded wrongly, moves the insert or timeout pulse by at least one cycle. The bench matches every pulse against the exact cycle number it expects, so such an error is caught at the first event. A detect wait that should have been dropped, or a data timer that should have stopped, produces an event the scoreboard did not expect. That event is flagged within the programmed wait. A timer that fails to count card-clock enables correctly shows up as a wrong expiry cycle in the half-rate test.

// File: rtl/sdc_timer_pkg.sv
package sdc_timer_pkg;
  localparam int FIELD_W   = 4;
  localparam int MAX_SHIFT = (1 << FIELD_W) - 2;
  localparam int DET_LSB   = 0;
  localparam int DATA_LSB  = 4;
  localparam int BUS_BIT   = 15;

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_INSERT  = 2'd1,
    EV_REMOVE  = 2'd2,
    EV_TIMEOUT = 2'd3
  } sdc_event_e;

  function automatic int limit_width(input int base, input int test);
    int top;
    top = base << MAX_SHIFT;
    if (test > top) top = test;
    return $clog2(top + 1);
  endfunction
endpackage

// File: rtl/sdc_limit_dec.sv
module sdc_limit_dec #(
  parameter int BASE = 1024,
  parameter int TEST = 256,
  parameter int W    = 25
) (
  input  logic [sdc_timer_pkg::FIELD_W-1:0] field_i,
  output logic [W-1:0]                      limit_o
);
  localparam logic [sdc_timer_pkg::FIELD_W-1:0] TEST_CODE = '1;

  always_comb begin
    if (field_i == TEST_CODE) limit_o = W'(TEST);
    else                      limit_o = W'(BASE) << field_i;
  end
endmodule

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d_i;
        else            chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdc_detect.sv
module sdc_detect #(
  parameter int W = 25
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         present_i,
  input  logic [W-1:0] limit_i,
  output logic         detected_o,
  output logic         insert_o,
  output logic         remove_o
);
  logic         prev_q, armed_q;
  logic [W-1:0] cnt_q;
  logic         rise, fall;

  assign rise = present_i & ~prev_q;
  assign fall = ~present_i & prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= 1'b0;
      armed_q    <= 1'b0;
      cnt_q      <= '0;
      detected_o <= 1'b0;
      insert_o   <= 1'b0;
      remove_o   <= 1'b0;
    end else begin
      prev_q   <= present_i;
      insert_o <= 1'b0;
      remove_o <= 1'b0;
      if (rise) begin
        cnt_q   <= limit_i - W'(1);
        armed_q <= 1'b1;
      end else if (fall) begin
        armed_q    <= 1'b0;
        detected_o <= 1'b0;
        remove_o   <= 1'b1;
      end else if (armed_q) begin
        if (cnt_q == '0) begin
          armed_q    <= 1'b0;
          detected_o <= 1'b1;
          insert_o   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sdc_data_timer.sv
module sdc_data_timer #(
  parameter int W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wait_i,
  input  logic         start_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         timeout_o
);
  logic         run_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      if (wait_i) begin
        cnt_q <= limit_i - W'(1);
        run_q <= 1'b1;
      end else if (start_i) begin
        run_q <= 1'b0;
      end else if (run_q && tick_i) begin
        if (cnt_q == '0) begin
          run_q     <= 1'b0;
          timeout_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sdc_card_timers.sv
module sdc_card_timers #(
  parameter int DET_BASE    = 32'h400,
  parameter int DATA_BASE   = 32'h2000,
  parameter int TEST_CNT    = 32'h100,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] option_i,
  input  logic        card_present_i,
  input  logic        data_wait_i,
  input  logic        data_start_i,
  input  logic        card_clk_en_i,
  output logic        card_detected_o,
  output logic        insert_evt_o,
  output logic        remove_evt_o,
  output logic        data_timeout_o,
  output logic        bus_1bit_o
);
  import sdc_timer_pkg::*;

  localparam int DET_W  = limit_width(DET_BASE, TEST_CNT);
  localparam int DATA_W = limit_width(DATA_BASE, TEST_CNT);

  logic [DET_W-1:0]  det_limit;
  logic [DATA_W-1:0] data_limit;
  logic              present_sync;

  sdc_limit_dec #(.BASE(DET_BASE), .TEST(TEST_CNT), .W(DET_W)) u_det_lim (
    .field_i (option_i[DET_LSB +: FIELD_W]),
    .limit_o (det_limit)
  );

  sdc_limit_dec #(.BASE(DATA_BASE), .TEST(TEST_CNT), .W(DATA_W)) u_data_lim (
    .field_i (option_i[DATA_LSB +: FIELD_W]),
    .limit_o (data_limit)
  );

  sdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (card_present_i),
    .q_o    (present_sync)
  );

  sdc_detect #(.W(DET_W)) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .present_i  (present_sync),
    .limit_i    (det_limit),
    .detected_o (card_detected_o),
    .insert_o   (insert_evt_o),
    .remove_o   (remove_evt_o)
  );

  sdc_data_timer #(.W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wait_i    (data_wait_i),
    .start_i   (data_start_i),
    .tick_i    (card_clk_en_i),
    .limit_i   (data_limit),
    .timeout_o (data_timeout_o)
  );

  assign bus_1bit_o = option_i[BUS_BIT];
endmodule

// File: rtl/sdc_card_timers_checker.sv
module sdc_card_timers_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic data_wait_i,
  input logic data_start_i,
  input logic card_clk_en_i,
  input logic card_detected_o,
  input logic insert_evt_o,
  input logic remove_evt_o,
  input logic data_timeout_o
);
  p_insert_sets_det_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insert_evt_o |-> card_detected_o);
  p_det_rise_has_insert_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_detected_o) |-> insert_evt_o);
  p_timeout_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_timeout_o |-> $past(card_clk_en_i));
  p_remove_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remove_evt_o |-> !card_detected_o);
  p_det_fall_has_remove_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(card_detected_o) |-> remove_evt_o);
  p_start_stops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_start_i && !data_wait_i) |=> !data_timeout_o);
  p_insert_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insert_evt_o |=> !insert_evt_o);
  p_remove_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remove_evt_o |=> !remove_evt_o);
  p_timeout_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_timeout_o |=> !data_timeout_o);
  p_events_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({insert_evt_o, remove_evt_o}));
endmodule

bind sdc_card_timers sdc_card_timers_checker u_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .data_wait_i     (data_wait_i),
  .data_start_i    (data_start_i),
  .card_clk_en_i   (card_clk_en_i),
  .card_detected_o (card_detected_o),
  .insert_evt_o    (insert_evt_o),
  .remove_evt_o    (remove_evt_o),
  .data_timeout_o  (data_timeout_o)
);

// File: tb/sdc_card_timers_bench.sv
`timescale 1ns/1ps
module sdc_card_timers_bench;
  localparam int DET_BASE  = 4;
  localparam int DATA_BASE = 8;
  localparam int TEST_CNT  = 20;
  localparam int SYNC_LAT  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opt = '0;
  logic        present = 1'b0, wait_s = 1'b0, start_s = 1'b0, clk_en = 1'b1;
  logic        detected, ins, rem, tmo, bus1;

  always #2 clk = ~clk;

  sdc_card_timers #(.DET_BASE(DET_BASE), .DATA_BASE(DATA_BASE), .TEST_CNT(TEST_CNT))
  u_sdc_card_timers (
    .clk_i(clk), .rst_ni(rst_n), .option_i(opt), .card_present_i(present),
    .data_wait_i(wait_s), .data_start_i(start_s), .card_clk_en_i(clk_en),
    .card_detected_o(detected), .insert_evt_o(ins), .remove_evt_o(rem),
    .data_timeout_o(tmo), .bus_1bit_o(bus1)
  );

  typedef struct { int kind; int unsigned at; string req; } exp_t;
  exp_t sb[$];
  int unsigned cyc = 0;
  int checks = 0, fails = 0;
  bit half = 1'b0, done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) clk_en = half ? (((cyc + 1) % 2) == 0) : 1'b1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pop and compare each event as it appears
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 1; k <= 3; k++) begin
        bit hit;
        hit = (k == 1) ? ins : (k == 2) ? rem : tmo;
        if (hit) begin
          if (sb.size() == 0) begin
            check(1'b0, "R8", $sformatf("unexpected event kind %0d at cycle", k), cyc, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.kind == k && e.at == cyc, e.req,
                  $sformatf("event kind %0d (expected kind %0d) cycle", k, e.kind), cyc, e.at);
          end
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int det_len(int d);
    return (d == 15) ? TEST_CNT : (DET_BASE << d);
  endfunction

  function automatic int data_len(int f);
    return (f == 15) ? TEST_CNT : (DATA_BASE << f);
  endfunction

  task automatic push(int kind, int unsigned at, string req);
    exp_t e;
    e.kind = kind; e.at = at; e.req = req;
    sb.push_back(e);
  endtask

  task automatic insert_card(int d, bit expect_ev, string req);
    opt[3:0] = 4'(d);
    present = 1'b1;
    if (expect_ev) push(1, cyc + det_len(d) + SYNC_LAT, req);
  endtask

  task automatic remove_card(string req);
    present = 1'b0;
    push(2, cyc + SYNC_LAT, req);
  endtask

  task automatic strobe(int f, bit expect_ev, string req);
    int unsigned t;
    int k;
    opt[7:4] = 4'(f);
    t = cyc + 1;
    k = 0;
    while (k < data_len(f)) begin
      t++;
      if (!half || (t % 2) == 0) k++;
    end
    if (expect_ev) push(3, t, req);
    wait_s = 1'b1;
    tick(1);
    wait_s = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (sb.size() != 0 && guard < 5000) begin
      tick(1);
      guard++;
    end
    tick(3);
  endtask

  task automatic finish_run();
    done = 1'b1;
    check(sb.size() == 0, "R8", "missing events in queue", sb.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      check(1'b0, "watchdog", "run exceeded cycle", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    opt = 16'h0001;
    present = 1'b1;
    tick(4);
    // R10: outputs quiet in reset even with card present
    check({detected, ins, rem, tmo} == 4'b0, "R10", "outputs in reset", {detected, ins, rem, tmo}, 0);
    rst_n = 1'b1;
    push(1, cyc + det_len(1) + SYNC_LAT, "R4");
    drain();
    check(detected == 1'b1, "R4", "detected after reset insertion", detected, 1);
    tick(20);
    check(detected == 1'b1, "R11", "detected held while present", detected, 1);

    remove_card("R5");
    drain();
    check(detected == 1'b0, "R5", "detected after removal", detected, 0);

    insert_card(0, 1'b1, "R1");
    drain();
    check(detected == 1'b1, "R1", "detected after shortest wait", detected, 1);
    remove_card("R5");
    drain();

    insert_card(2, 1'b1, "R1");
    drain();
    remove_card("R5");
    drain();

    // abandoned detect count: removal before expiry, no insert may follow
    insert_card(2, 1'b0, "R5");
    tick(6);
    remove_card("R5");
    tick(det_len(2) + 10);
    check(detected == 1'b0, "R5", "detected after abandoned wait", detected, 0);
    check(sb.size() == 0, "R5", "pending events after abandon", sb.size(), 0);

    insert_card(15, 1'b1, "R2");
    drain();

    strobe(0, 1'b1, "R3");
    drain();
    strobe(2, 1'b1, "R3");
    drain();

    half = 1'b1;
    tick(2);
    strobe(1, 1'b1, "R3");
    drain();
    half = 1'b0;
    tick(2);

    strobe(0, 1'b0, "R6");
    tick(5);
    strobe(0, 1'b1, "R6");
    drain();

    strobe(1, 1'b0, "R7");
    tick(3);
    start_s = 1'b1;
    tick(1);
    start_s = 1'b0;
    tick(data_len(1) + 10);
    check(tmo == 1'b0 && sb.size() == 0, "R7", "timeout after data start", tmo, 0);

    strobe(15, 1'b1, "R2");
    drain();

    opt[15] = 1'b1;
    tick(1);
    check(bus1 == 1'b1, "R9", "one-bit bus flag", bus1, 1);
    opt[15] = 1'b0;
    tick(1);
    check(bus1 == 1'b0, "R9", "four-bit bus flag", bus1, 0);

    check(detected == 1'b1, "R11", "detected still held", detected, 1);
    finish_run();
  end
endmodule